// File: doc/BRIEF.md
# Transmit Output Path Sequencer

This block chooses what the analog transmit output of a modem front end carries. Two level inputs control it: a modulator enable and a filter power request. From these two inputs it produces a source-select code for the analog switch matrix, an enable for the transmit low-pass filter's supply, and a flag that shows a start-up mute is in progress. The possible sources are the modulated signal through the transmit filter, the voice input through the same filter, the receive band-pass filter output, or the mid-rail idle level.

Switching on a switched-capacitor filter produces a transient. When the filter power request rises, the block therefore powers the filter at once but holds the output at idle for a fixed number of master clock cycles. This is roughly 2 ms at the nominal master clock. After the hold ends, the output moves to the filter. The hold length is the parameter `HOLD_CYCLES` and must be at least 1. Both inputs are registered once, so every output reflects the inputs sampled at the previous rising clock edge.

Top module: `tx_path_seq`

## Requirements
- R1: While `rst_n` is low, `src_sel` is 0, `flt_on` is 0 and `muted` is 0.
- R2: `src_sel` encodes 0 = idle mid-rail level, 1 = modulator through transmit filter, 2 = voice through transmit filter, 3 = receive band-pass output. All outputs change only on a rising clock edge and reflect the inputs sampled at that edge.
- R3: With `flt_pwr`=1 and `mod_en`=1, and the hold over, `src_sel` is 1 and `flt_on` is 1.
- R4: With `flt_pwr`=1 and `mod_en`=0, and the hold over, `src_sel` is 2 and `flt_on` is 1.
- R5: With `flt_pwr`=0 and `mod_en`=1, `src_sel` is 3, `flt_on` is 0 and `muted` is 0.
- R6: With both inputs 0, `src_sel` is 0, `flt_on` is 0 and `muted` is 0.
- R7: At the first edge that samples `flt_pwr`=1 after it was 0, `flt_on` goes to 1. For exactly `HOLD_CYCLES` cycles from that edge, `muted` is 1 and `src_sel` is 0. After that, the output moves to the filter source.
- R8: If `flt_pwr` returns to 0 during the hold, the next edge clears `muted` and `flt_on`. A later rise starts a full new hold of `HOLD_CYCLES` cycles.
- R9: Toggling `mod_en` during the hold neither shortens nor lengthens it. The source chosen when the hold ends follows the `mod_en` value sampled at that edge.
- R10: Once the hold is over and `flt_pwr` stays 1, changes of `mod_en` switch `src_sel` directly between 1 and 2 without muting again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Modulator enable (1 = modulated data, 0 = voice or receive path) |
| flt_pwr | input | 1 | Transmit filter power request |
| src_sel | output | 2 | Output source code (see R2) |
| flt_on | output | 1 | Transmit filter supply enable |
| muted | output | 1 | Start-up hold in progress |

## Verification
The bench measures the exact length of the hold. An off-by-one counter would give one cycle too many or too few of idle output after the filter powers up. It drops the power request partway through a hold and then raises it again. A design that kept the old count would end the second hold early, and one that kept the mute flag would hold the output idle with the filter off. It toggles the modulator enable during the hold and after it. A wrong design would cut the mute short, re-mute on a source change, or latch a stale selection when the hold ends. Random runs of both inputs cover every pairing, including the receive-filter route that must never power the transmit filter.

// File: rtl/tx_path_seq.sv
module tx_path_seq #(
  parameter int HOLD_CYCLES = 7373
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mod_en,
  input  logic       flt_pwr,
  output logic [1:0] src_sel,
  output logic       flt_on,
  output logic       muted
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES);
  localparam logic [1:0] SRC_IDLE  = 2'd0;
  localparam logic [1:0] SRC_MOD   = 2'd1;
  localparam logic [1:0] SRC_VOICE = 2'd2;
  localparam logic [1:0] SRC_RXF   = 2'd3;

  logic          pwr_q, mod_q, done;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= 1'b0;
      mod_q <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
    end else begin
      pwr_q <= flt_pwr;
      mod_q <= mod_en;
      if (!flt_pwr) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (!done) begin
        if (cnt == LAST) done <= 1'b1;
        else             cnt  <= cnt + 1'b1;
      end
    end
  end

  assign flt_on  = pwr_q;
  assign muted   = pwr_q & ~done;
  assign src_sel = !pwr_q ? (mod_q ? SRC_RXF : SRC_IDLE)
                 : (!done ? SRC_IDLE : (mod_q ? SRC_MOD : SRC_VOICE));

  // R3
  filter_src_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_MOD || src_sel == SRC_VOICE) |-> flt_on);
  // R5
  rx_route_filter_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_RXF) |-> (!flt_on && !muted));
  // R7
  mute_on_power_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_on) |-> (muted && src_sel == SRC_IDLE));
  // R8
  mute_clears_with_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_on) |-> !muted);
  // R10
  no_remute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_on && !muted) |=> (!flt_on || !muted));
  // R7
  mute_implies_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    muted |-> (src_sel == SRC_IDLE && flt_on));
endmodule

// File: tb/sim_tx_path_seq.sv
`timescale 1ns/1ps
module sim_tx_path_seq;
  localparam int HOLD = 16;
  logic clk = 1'b0, rst_n = 1'b0, mod_en = 1'b0, flt_pwr = 1'b0;
  logic [1:0] src_sel;
  logic flt_on, muted;
  int checks = 0, errors = 0;
  bit done_flag = 1'b0;

  tx_path_seq #(.HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .flt_pwr(flt_pwr),
    .src_sel(src_sel), .flt_on(flt_on), .muted(muted));

  always #2.5 clk = ~clk;

  logic m_pwr = 1'b0, m_mod = 1'b0;
  int age = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwr <= 1'b0; m_mod <= 1'b0; age <= 0;
    end else begin
      m_pwr <= flt_pwr;
      m_mod <= mod_en;
      age   <= flt_pwr ? ((age <= HOLD) ? age + 1 : age) : 0;
    end
  end

  function automatic logic exp_mute(input logic p, input int a);
    return p && (a <= HOLD);
  endfunction
  function automatic logic [1:0] exp_src(input logic p, input logic m, input int a);
    if (!p) return m ? 2'd3 : 2'd0;
    if (exp_mute(p, a)) return 2'd0;
    return m ? 2'd1 : 2'd2;
  endfunction
  function automatic string tag_of(input logic p, input logic m, input int a);
    if (!p) return m ? "R5" : "R6";
    if (exp_mute(p, a)) return "R7";
    return m ? "R3" : "R4";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      check({tag_of(m_pwr, m_mod, age), " src"}, src_sel, exp_src(m_pwr, m_mod, age));
      check({tag_of(m_pwr, m_mod, age), " flt_on"}, flt_on, m_pwr);
      check({tag_of(m_pwr, m_mod, age), " muted"}, muted, exp_mute(m_pwr, age));
    end
  end

  task automatic tick(input logic p, input logic m);
    flt_pwr = p; mod_en = m;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 src", src_sel, 0);
    check("R1 flt_on", flt_on, 0);
    check("R1 muted", muted, 0);
    rst_n = 1'b1;

    // R2 / R6 / R5 idle and receive routes
    tick(0, 0); check("R6 src", src_sel, 0);
    tick(0, 1); check("R5 src", src_sel, 3); check("R2 flt_on", flt_on, 0);

    // R7 exact hold length
    n = 0; tick(1, 1);
    while (muted && n < 200) begin n++; tick(1, 1); end
    check("R7 hold length", n, HOLD);
    check("R3 src after hold", src_sel, 1);

    // R10 toggling after hold
    tick(1, 0); check("R10 src", src_sel, 2); check("R10 muted", muted, 0);
    tick(1, 1); check("R10 src", src_sel, 1); check("R10 muted", muted, 0);

    // R8 drop during hold, then full restart
    tick(0, 1); tick(0, 1);
    repeat (5) tick(1, 1);
    check("R8 mid-hold muted", muted, 1);
    tick(0, 1); check("R8 muted cleared", muted, 0); check("R8 flt_on off", flt_on, 0);
    n = 0; tick(1, 1);
    while (muted && n < 200) begin n++; tick(1, 1); end
    check("R8 restarted hold length", n, HOLD);

    // R9 mod toggles during hold
    tick(0, 0);
    n = 0; tick(1, 0);
    while (muted && n < 200) begin n++; tick(1, logic'(n[0])); end
    check("R9 hold length with toggling", n, HOLD);
    tick(1, 0); check("R9 selection follows mod_en", src_sel, 2);

    // random runs
    for (int i = 0; i < 400; i++) begin
      logic p, m;
      int len;
      p = logic'($urandom_range(0, 1));
      m = logic'($urandom_range(0, 1));
      len = $urandom_range(1, 2 * HOLD + 4);
      for (int j = 0; j < len; j++) begin
        if ($urandom_range(0, 7) == 0) m = ~m;
        tick(p, m);
      end
    end
    finish_run();
  end
endmodule